// File: doc/BRIEF.md
# Cascadable Down-Counter Timer Bank

This block holds four 8-bit down-counting timers that share one byte-wide register bus. Every timer owns a count register and a reload register, and software can read and write both. On each cycle where the shared tick input is high, an enabled timer steps its count down by one. When the count reaches zero the timer posts a sticky interrupt flag. It then either copies its reload value back into the count (auto-reload) or stops at zero and drops its own enable bit (single-shot).

Timers 0 and 1 can run alone or be joined into one 16-bit timer. Timers 2 and 3 are always joined. A joined pair keeps its low byte in the even timer and its high byte in the odd timer. It reloads on every zero crossing, runs freely while its flag is still pending, and reports only on the even timer's interrupt line. When writes collide in one cycle, the block settles them in a fixed order: a software write to a count register beats the hardware decrement, and the hardware clear of a single-shot enable bit beats a software write to the control register.

Top module: `cascade_timer_bank`

## Requirements
- R1: After reset every register reads zero, all timers are disabled and all four interrupt outputs are low.
- R2: The count register of timer t is at byte address 2t and its reload register is at 2t+1. The control register is at address 8, with bits 3:0 enabling timers 0..3 and bits 7:4 selecting auto-reload for timers 0..3. The join register is at address 9, bit 0, and joins timers 0 and 1. The status flags are at address 10, bits 3:0. Read data appears on `rdata` one cycle after `addr` is presented, and reading changes no state.
- R3: An enabled timer decrements by exactly one on each cycle where `tick` is high. With `tick` low its count holds.
- R4: A tick that finds a count of 1 or 0 is a zero event. On the same clock edge it sets the timer's status flag, and in auto-reload mode it loads the reload value into the count.
- R5: A zero event in single-shot mode leaves the count at 0 and clears that timer's enable bit, so further ticks have no effect.
- R6: Status flags stay set until software writes 1 to the bit at address 10. If a zero event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R7: In a joined pair the even timer holds the low byte and the odd timer the high byte. The pair decrements as one 16-bit value, with a borrow across the bytes. It runs on the even timer's enable bit, always reloads both bytes at a zero event, keeps the even enable bit set, and raises only the even timer's flag.
- R8: Timers 2 and 3 always behave as a joined pair, whatever the join bit holds. The join bit affects timers 0 and 1 only.
- R9: A software write to a count register in the same cycle as a decrement leaves the written value. A reload value written while the timer runs is used at the next zero event.
- R10: If hardware clears a single-shot enable bit in the same cycle that software writes 1 to that bit, the bit ends up cleared.
- R11: A joined pair keeps counting and reloading while its status flag is still set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-advance enable, one step per high cycle |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register byte address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data for `addr` |
| irq | output | 4 | Sticky interrupt flag per timer |

## Verification
A write, a tick and a zero event all take effect on the clock edge that ends their cycle. Counts, enables and flags therefore change at that edge, and `irq` can be sampled half a period later. Read data is registered, so each read holds `addr` for one full cycle and samples `rdata` at the next falling edge. The bench drives every stimulus at a falling edge and samples only at falling edges, so each check lands exactly one edge after its cause. The collision cases (write with tick, clear with zero event) are driven within a single cycle, so that both sides truly coincide.

// File: rtl/ctb_pkg.sv
package ctb_pkg;
  localparam int NUM_TMR = 4;
  localparam int ADDR_W  = 4;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'd8;
  localparam logic [ADDR_W-1:0] A_JOIN = 4'd9;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd10;
endpackage

// File: rtl/cdt_pair.sv
module cdt_pair #(
  parameter int W           = 8,
  parameter bit ALWAYS_JOIN = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                join_i,
  input  logic [1:0]          en_i,
  input  logic [1:0]          arl_i,
  input  logic [1:0]          wr_cnt_i,
  input  logic [1:0]          wr_rl_i,
  input  logic [W-1:0]        wdata_i,
  output logic [1:0][W-1:0]   cnt_o,
  output logic [1:0][W-1:0]   rl_o,
  output logic [1:0]          evt_o,
  output logic [1:0]          ss_clr_o
);
  localparam logic [W-1:0]   ONE8  = W'(1);
  localparam logic [2*W-1:0] ONE16 = (2*W)'(1);

  logic [1:0][W-1:0] cnt_q, rl_q, cnt_nx;
  logic              joined;
  logic [2*W-1:0]    v16;

  assign joined = ALWAYS_JOIN | join_i;
  assign v16    = cnt_q;

  always_comb begin
    cnt_nx   = cnt_q;
    evt_o    = '0;
    ss_clr_o = '0;
    if (joined) begin
      if (en_i[0] && tick) begin
        if (v16 <= ONE16) begin
          evt_o[0] = 1'b1;
          cnt_nx   = rl_q;
        end else begin
          cnt_nx = v16 - ONE16;
        end
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (en_i[i] && tick) begin
          if (cnt_q[i] <= ONE8) begin
            evt_o[i] = 1'b1;
            if (arl_i[i]) begin
              cnt_nx[i] = rl_q[i];
            end else begin
              cnt_nx[i]    = '0;
              ss_clr_o[i]  = 1'b1;
            end
          end else begin
            cnt_nx[i] = cnt_q[i] - ONE8;
          end
        end
      end
    end
    for (int i = 0; i < 2; i++) begin
      if (wr_cnt_i[i]) cnt_nx[i] = wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rl_q  <= '0;
    end else begin
      cnt_q <= cnt_nx;
      for (int i = 0; i < 2; i++) begin
        if (wr_rl_i[i]) rl_q[i] <= wdata_i;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign rl_o  = rl_q;

  for (genvar g = 0; g < 2; g++) begin : g_chk
    assert_step_down_R3: assert property (@(posedge clk) disable iff (rst)
      (!joined && en_i[g] && tick && cnt_q[g] > ONE8 && !wr_cnt_i[g])
      |=> cnt_q[g] == W'($past(cnt_q[g]) - ONE8));
    assert_sw_wins_R9: assert property (@(posedge clk) disable iff (rst)
      wr_cnt_i[g] |=> cnt_q[g] == $past(wdata_i));
    assert_oneshot_zero_R5: assert property (@(posedge clk) disable iff (rst)
      (!joined && evt_o[g] && !arl_i[g] && !wr_cnt_i[g]) |=> cnt_q[g] == '0);
  end

  assert_join_reload_R7: assert property (@(posedge clk) disable iff (rst)
    (joined && evt_o[0] && wr_cnt_i == 2'b00 && wr_rl_i == 2'b00)
    |=> cnt_q == $past(rl_q));
  assert_join_odd_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    joined |-> !evt_o[1] && ss_clr_o == 2'b00);
endmodule

// File: rtl/cdt_ctrl.sv
module cdt_ctrl #(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_ctrl_i,
  input  logic         wr_join_i,
  input  logic         wr_stat_i,
  input  logic [W-1:0] wdata_i,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] en_o,
  output logic [N-1:0] arl_o,
  output logic         join_o,
  output logic [N-1:0] irq_o
);
  logic [N-1:0] en_q, arl_q, irq_q, en_nx, arl_nx, irq_nx, w1c;
  logic         join_q;

  always_comb begin
    en_nx  = wr_ctrl_i ? wdata_i[N-1:0]   : en_q;
    arl_nx = wr_ctrl_i ? wdata_i[2*N-1:N] : arl_q;
    en_nx  = en_nx & ~clr_i;
    w1c    = wr_stat_i ? wdata_i[N-1:0] : '0;
    irq_nx = (irq_q & ~w1c) | evt_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      arl_q  <= '0;
      irq_q  <= '0;
      join_q <= 1'b0;
    end else begin
      en_q  <= en_nx;
      arl_q <= arl_nx;
      irq_q <= irq_nx;
      if (wr_join_i) join_q <= wdata_i[0];
    end
  end

  assign en_o   = en_q;
  assign arl_o  = arl_q;
  assign join_o = join_q;
  assign irq_o  = irq_q;

  for (genvar g = 0; g < N; g++) begin : g_chk
    assert_hw_clear_wins_R10: assert property (@(posedge clk) disable iff (rst)
      clr_i[g] |=> !en_q[g]);
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
      (irq_q[g] && !(wr_stat_i && wdata_i[g])) |=> irq_q[g]);
    assert_flag_set_R4: assert property (@(posedge clk) disable iff (rst)
      evt_i[g] |=> irq_q[g]);
  end
endmodule

// File: rtl/cascade_timer_bank.sv
module cascade_timer_bank
  import ctb_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [CNT_W-1:0]   wdata,
  output logic [CNT_W-1:0]   rdata,
  output logic [NUM_TMR-1:0] irq
);
  localparam int NPAIR = NUM_TMR / 2;
  localparam int IDX_W = $clog2(NUM_TMR);

  logic [NUM_TMR-1:0]            en, arl, evt, clr, wr_cnt, wr_rl;
  logic [NUM_TMR-1:0][CNT_W-1:0] cnt, rl;
  logic                          join01;
  logic [CNT_W-1:0]              rd_nx;
  logic [IDX_W-1:0]              idx;

  always_comb begin
    for (int t = 0; t < NUM_TMR; t++) begin
      wr_cnt[t] = wr_en && (addr == ADDR_W'(2 * t));
      wr_rl[t]  = wr_en && (addr == ADDR_W'(2 * t + 1));
    end
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    cdt_pair #(.W(CNT_W), .ALWAYS_JOIN(p != 0)) u_pair (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick),
      .join_i   (join01),
      .en_i     (en[2*p+1:2*p]),
      .arl_i    (arl[2*p+1:2*p]),
      .wr_cnt_i (wr_cnt[2*p+1:2*p]),
      .wr_rl_i  (wr_rl[2*p+1:2*p]),
      .wdata_i  (wdata),
      .cnt_o    (cnt[2*p+1:2*p]),
      .rl_o     (rl[2*p+1:2*p]),
      .evt_o    (evt[2*p+1:2*p]),
      .ss_clr_o (clr[2*p+1:2*p])
    );
  end

  cdt_ctrl #(.N(NUM_TMR), .W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_ctrl_i (wr_en && addr == A_CTRL),
    .wr_join_i (wr_en && addr == A_JOIN),
    .wr_stat_i (wr_en && addr == A_STAT),
    .wdata_i   (wdata),
    .evt_i     (evt),
    .clr_i     (clr),
    .en_o      (en),
    .arl_o     (arl),
    .join_o    (join01),
    .irq_o     (irq)
  );

  assign idx = addr[IDX_W:1];

  always_comb begin
    rd_nx = '0;
    if (addr < ADDR_W'(2 * NUM_TMR)) begin
      rd_nx = addr[0] ? rl[idx] : cnt[idx];
    end else if (addr == A_CTRL) begin
      rd_nx = CNT_W'({arl, en});
    end else if (addr == A_JOIN) begin
      rd_nx = CNT_W'(join01);
    end else if (addr == A_STAT) begin
      rd_nx = CNT_W'(irq);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_nx;
  end

  assert_upper_pair_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !evt[NUM_TMR-1]);
  assert_read_no_effect_R2: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !tick) |=> $stable(cnt) && $stable(rl) && $stable(en));
endmodule

// File: tb/cascade_timer_bank_tb.sv
`timescale 1ns/1ps
module cascade_timer_bank_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [3:0] irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cascade_timer_bank dut_i (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr_tick(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
    end
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic t_reset();
    int v;
    for (int a = 0; a < 11; a++) begin
      rd(4'(a), v);
      chk($sformatf("R1 reset reg %0d", a), v, 0);
    end
    chk("R1 reset irq", irq, 0);
  endtask

  task automatic t_indep_reload();
    int v;
    wr(4'd1, 8'd7);
    wr(4'd0, 8'd5);
    rd(4'd0, v); chk("R2 count0 readback", v, 5);
    wr(4'd8, 8'h11);
    repeat (5) @(negedge clk);
    rd(4'd0, v); chk("R3 holds without tick", v, 5);
    ticks(3);
    rd(4'd0, v); chk("R3 three steps", v, 2);
    chk("R4 no flag early", irq[0], 0);
    ticks(1);
    ticks(1);
    rd(4'd0, v); chk("R4 reload on zero", v, 7);
    chk("R4 flag set", irq[0], 1);
    rd(4'd1, v); chk("R2 reload reg kept", v, 7);
  endtask

  task automatic t_sticky();
    int v;
    ticks(2);
    chk("R6 flag sticky", irq[0], 1);
    rd(4'd10, v); chk("R2 status read", v, 1);
    rd(4'd10, v); chk("R2 status read twice", v, 1);
    rd(4'd0, v); chk("R2 read has no effect", v, 5);
    wr(4'd10, 8'h01);
    chk("R6 write-one clears", irq[0], 0);
    wr(4'd0, 8'd1);
    wr_tick(4'd10, 8'h01);
    chk("R6 set beats clear", irq[0], 1);
    rd(4'd0, v); chk("R4 reload in collision", v, 7);
    wr(4'd10, 8'h01);
  endtask

  task automatic t_single();
    int v;
    wr(4'd3, 8'd9);
    wr(4'd2, 8'd3);
    wr(4'd8, 8'h12);
    ticks(2);
    rd(4'd2, v); chk("R3 timer1 count", v, 1);
    chk("R5 no flag yet", irq[1], 0);
    ticks(1);
    rd(4'd2, v); chk("R5 stops at zero", v, 0);
    chk("R5 flag", irq[1], 1);
    rd(4'd8, v); chk("R5 enable cleared", v, 8'h10);
    ticks(2);
    rd(4'd2, v); chk("R5 stays at zero", v, 0);
    wr(4'd10, 8'h02);
  endtask

  task automatic t_sw_priority();
    int v;
    wr(4'd0, 8'h30);
    wr(4'd8, 8'h11);
    wr_tick(4'd0, 8'h40);
    rd(4'd0, v); chk("R9 write beats decrement", v, 8'h40);
    ticks(1);
    rd(4'd0, v); chk("R3 counts from written value", v, 8'h3F);
    wr(4'd1, 8'h22);
    wr(4'd0, 8'd2);
    ticks(2);
    rd(4'd0, v); chk("R9 new reload used", v, 8'h22);
    wr(4'd8, 8'h00);
    wr(4'd10, 8'h0F);
  endtask

  task automatic t_hw_clear();
    int v;
    wr(4'd2, 8'd1);
    wr(4'd8, 8'h12);
    wr_tick(4'd8, 8'h12);
    rd(4'd8, v); chk("R10 hardware clear wins", v, 8'h10);
    chk("R10 flag on zero", irq[1], 1);
    wr(4'd8, 8'h00);
    wr(4'd10, 8'h0F);
  endtask

  task automatic t_join01();
    int v;
    wr(4'd9, 8'h01);
    wr(4'd0, 8'h01);
    wr(4'd2, 8'h01);
    wr(4'd1, 8'h03);
    wr(4'd3, 8'h00);
    wr(4'd8, 8'h01);
    ticks(2);
    rd(4'd0, v); chk("R7 low byte after borrow", v, 8'hFF);
    rd(4'd2, v); chk("R7 high byte after borrow", v, 8'h00);
    wr(4'd0, 8'h02);
    ticks(1);
    ticks(1);
    rd(4'd0, v); chk("R7 low byte reloaded", v, 3);
    rd(4'd2, v); chk("R7 high byte reloaded", v, 0);
    chk("R7 only even flag", irq, 4'b0001);
    rd(4'd8, v); chk("R7 enable kept", v, 8'h01);
    ticks(1);
    rd(4'd0, v); chk("R11 counts while pending", v, 2);
    ticks(2);
    rd(4'd0, v); chk("R11 reloads while pending", v, 3);
    chk("R11 flag still set", irq, 4'b0001);
    wr(4'd8, 8'h00);
    wr(4'd10, 8'h0F);
    wr(4'd9, 8'h00);
  endtask

  task automatic t_join23();
    int v;
    wr(4'd4, 8'h00);
    wr(4'd6, 8'h01);
    wr(4'd5, 8'h04);
    wr(4'd7, 8'h00);
    wr(4'd8, 8'h04);
    ticks(1);
    rd(4'd4, v); chk("R8 low byte borrow", v, 8'hFF);
    rd(4'd6, v); chk("R8 high byte borrow", v, 8'h00);
    chk("R8 no flag mid-count", irq, 0);
    wr(4'd4, 8'h01);
    ticks(1);
    chk("R8 flag on timer2 only", irq, 4'b0100);
    rd(4'd4, v); chk("R8 low byte reloaded", v, 4);
    rd(4'd6, v); chk("R8 high byte reloaded", v, 0);
    rd(4'd8, v); chk("R8 enable kept", v, 8'h04);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_indep_reload();
    t_sticky();
    t_single();
    t_sw_priority();
    t_hw_clear();
    t_join01();
    t_join23();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule